// File: doc/BRIEF.md
# Base-and-Bounds Address Relocation Unit

This block stands between the 18-bit word addresses a program produces and the memory system. One 18-bit relocation register holds two fields, each counted in 1024-word blocks: a base block number and the number of blocks granted to the program. Each request is checked first. If the block index of the virtual address is not below the granted block count, the request is refused with a protection fault. Otherwise the base, shifted into word units, is added to the address and the sum is issued as the physical address.

Privileged requests skip both the check and the addition. The current register value is also presented on an output port, so an I/O controller can take it along with a transfer request and relocate its own virtual addresses in the same way. Every request resolves one cycle after it is presented. A register load takes effect at the next clock edge.

Top module: `base_bounds_reloc`

## Requirements
- R1: After synchronous reset, the relocation register reads 0. No memory request and no fault is issued in the first cycle after reset.
- R2: The register layout is base block number in bits [17:9] and granted block count in bits [8:0]. When `load_en` is high, `ctx_word` shows `load_word` from the next cycle onward. Otherwise it holds its value.
- R3: A non-privileged request whose address bits [17:10] are greater than or equal to the block count gives `fault_valid` high and `mem_valid` low one cycle later.
- R4: A non-privileged request that passes the check gives `mem_valid` high one cycle later, with `mem_addr` equal to the virtual address plus base times 1024.
- R5: A privileged request is never faulted. It gives `mem_valid` one cycle later, with `mem_addr` equal to the unchanged virtual address.
- R6: A request presented in the same cycle as a load is checked and relocated with the value the register held before that load.
- R7: The relocated sum is truncated to 18 bits, so a base plus offset past the top of memory wraps around to low addresses.
- R8: In a cycle after one with `req_valid` low, both `mem_valid` and `fault_valid` are low.
- R9: When `fault_valid` is high, `fault_vaddr` carries the virtual address of the refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write the relocation register |
| load_word | input | 18 | New register value: base [17:9], count [8:0] |
| req_valid | input | 1 | A translation request is presented |
| req_vaddr | input | 18 | Virtual word address |
| req_priv | input | 1 | Privileged request, bypasses the check and relocation |
| ctx_word | output | 18 | Current register value, handed to I/O with each transfer |
| mem_valid | output | 1 | Physical access issued |
| mem_addr | output | 18 | Physical word address |
| fault_valid | output | 1 | Protection fault raised |
| fault_vaddr | output | 18 | Virtual address that faulted |

## Verification
The case that needs care is a register load and a request in the same cycle. The request must be judged against the old base and bound, while the new value must appear on `ctx_word` in the following cycle. The bench provokes this in two ways. First, it loads a context that would fault an address the old context allows, in the same cycle as a request to that address. Second, it does the reverse. In both cases it compares, in the following cycle, the issued address or the fault against a reference model that takes the old register value first and applies the load afterwards.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    parameter int ADDR_W    = 18;
    parameter int BLK_SHIFT = 10;
    parameter int FIELD_W   = ADDR_W / 2;
    localparam int IDX_W    = ADDR_W - BLK_SHIFT;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [FIELD_W-1:0] base_blk;
        logic [FIELD_W-1:0] blk_cnt;
    } ctx_t;

    typedef struct packed {
        logic  issue;
        logic  fault;
        addr_t addr;
        addr_t vaddr;
    } xlate_t;

    function automatic logic out_of_bounds(addr_t va, ctx_t c);
        logic [FIELD_W-1:0] idx;
        idx = FIELD_W'(va[ADDR_W-1:BLK_SHIFT]);
        return idx >= c.blk_cnt;
    endfunction

    function automatic addr_t relocate(addr_t va, ctx_t c);
        addr_t offs;
        offs = addr_t'({c.base_blk, {BLK_SHIFT{1'b0}}});
        return va + offs;
    endfunction
endpackage

// File: rtl/reloc_ctx_reg.sv
module reloc_ctx_reg
    import reloc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  ctx_t  load_val,
    output ctx_t  ctx_q
);
    // R1, R2: reset to zero, load visible next cycle
    always_ff @(posedge clk) begin
        if (rst)
            ctx_q <= '0;
        else if (load_en)
            ctx_q <= load_val;
    end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
    import reloc_pkg::*;
(
    input  logic   valid,
    input  addr_t  vaddr,
    input  logic   priv,
    input  ctx_t   ctx,
    output xlate_t res
);
    // R3, R4, R5, R7: check and relocate against the current register
    always_comb begin
        res       = '0;
        res.vaddr = vaddr;
        if (valid) begin
            if (priv) begin
                res.issue = 1'b1;
                res.addr  = vaddr;
            end else if (out_of_bounds(vaddr, ctx)) begin
                res.fault = 1'b1;
            end else begin
                res.issue = 1'b1;
                res.addr  = relocate(vaddr, ctx);
            end
        end
    end
endmodule

// File: rtl/reloc_out_stage.sv
module reloc_out_stage
    import reloc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xlate_t res,
    output logic   mem_valid,
    output addr_t  mem_addr,
    output logic   fault_valid,
    output addr_t  fault_vaddr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_valid   <= 1'b0;
            mem_addr    <= '0;
            fault_valid <= 1'b0;
            fault_vaddr <= '0;
        end else begin
            mem_valid   <= res.issue;
            fault_valid <= res.fault;
            if (res.issue)
                mem_addr <= res.addr;
            if (res.fault)
                fault_vaddr <= res.vaddr; // R9
        end
    end
endmodule

// File: rtl/base_bounds_reloc.sv
module base_bounds_reloc
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_word,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_priv,
    output logic [ADDR_W-1:0] ctx_word,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_vaddr
);
    ctx_t   ctx_q;
    xlate_t res;

    reloc_ctx_reg u_ctx (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (ctx_t'(load_word)),
        .ctx_q    (ctx_q)
    );

    // R6: the request sees ctx_q before any same-cycle load lands
    reloc_xlate u_xlate (
        .valid (req_valid),
        .vaddr (req_vaddr),
        .priv  (req_priv),
        .ctx   (ctx_q),
        .res   (res)
    );

    reloc_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .res         (res),
        .mem_valid   (mem_valid),
        .mem_addr    (mem_addr),
        .fault_valid (fault_valid),
        .fault_vaddr (fault_vaddr)
    );

    assign ctx_word = ctx_q;
endmodule

// File: rtl/base_bounds_reloc_chk.sv
module base_bounds_reloc_chk
    import reloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_word,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_priv,
    input  logic [ADDR_W-1:0] ctx_word,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              fault_valid,
    input  logic [ADDR_W-1:0] fault_vaddr
);
    assert_load_visible_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(load_en)) |-> ctx_word == $past(load_word));

    assert_fault_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && fault_valid));

    assert_priv_pass_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(req_valid) && $past(req_priv))
            |-> (mem_valid && !fault_valid && mem_addr == $past(req_vaddr)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(req_valid)) |-> (!mem_valid && !fault_valid));

    assert_fault_addr_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && fault_valid) |-> fault_vaddr == $past(req_vaddr));
endmodule

bind base_bounds_reloc base_bounds_reloc_chk u_chk (.*);

// File: tb/base_bounds_reloc_test.sv
`timescale 1ns/1ps
module base_bounds_reloc_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [17:0] load_word;
    logic        req_valid;
    logic [17:0] req_vaddr;
    logic        req_priv;
    logic [17:0] ctx_word;
    logic        mem_valid;
    logic [17:0] mem_addr;
    logic        fault_valid;
    logic [17:0] fault_vaddr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int model_ctx = 0;

    always #10 clk = ~clk;

    base_bounds_reloc uut (.*);

    task automatic check(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one cycle: present inputs, clock, then compare against the model
    task automatic step(bit ld, int lw, bit rv, int va, bit pv, string tag);
        int base, cnt, e_mv, e_fv, e_addr;
        @(negedge clk);
        load_en = ld; load_word = 18'(lw);
        req_valid = rv; req_vaddr = 18'(va); req_priv = pv;
        @(posedge clk);
        #2;
        base = model_ctx / 512;
        cnt  = model_ctx % 512;
        e_mv = 0; e_fv = 0; e_addr = 0;
        if (rv) begin
            if (pv) begin e_mv = 1; e_addr = va; end
            else if ((va / 1024) >= cnt) e_fv = 1;
            else begin e_mv = 1; e_addr = (va + base * 1024) % 262144; end
        end
        if (ld) model_ctx = lw;
        check(tag, "mem_valid", int'(mem_valid), e_mv);
        check(tag, "fault_valid", int'(fault_valid), e_fv);
        if (e_mv) check(tag, "mem_addr", int'(mem_addr), e_addr);
        if (e_fv) check("R9", "fault_vaddr", int'(fault_vaddr), va);
        check("R2", "ctx_word", int'(ctx_word), model_ctx);
    endtask

    function automatic int mk(int base, int cnt);
        return base * 512 + cnt;
    endfunction

    initial begin
        rst = 1'b1; load_en = 0; load_word = 0;
        req_valid = 0; req_vaddr = 0; req_priv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "ctx_word", int'(ctx_word), 0);
        check("R1", "mem_valid", int'(mem_valid), 0);
        check("R1", "fault_valid", int'(fault_valid), 0);
        // R1: zero count faults every user access
        step(0, 0, 1, 'h00010, 0, "R3");
        step(0, 0, 1, 'h00123, 1, "R5");
        // load base 5, count 4
        step(1, mk(5, 4), 0, 0, 0, "R8");
        step(0, 0, 1, 'h00000, 0, "R4");
        step(0, 0, 1, 'h00FFF, 0, "R4");     // last word of block 3
        step(0, 0, 1, 'h01000, 0, "R3");     // block 4 == count
        step(0, 0, 1, 'h3FFFF, 0, "R3");
        step(0, 0, 1, 'h3FFFF, 1, "R5");
        step(0, 0, 0, 'h00004, 0, "R8");
        // R6: load shrinks bound in same cycle as an allowed request
        step(1, mk(5, 1), 1, 'h00800, 0, "R6");
        step(0, 0, 1, 'h00800, 0, "R6");
        // R6: load grows bound in same cycle as a refused request
        step(1, mk(2, 300), 1, 'h02000, 0, "R6");
        step(0, 0, 1, 'h02000, 0, "R6");
        // R7 wrap: base 511, count 256 covers all of the 8-bit index
        step(1, mk(511, 256), 0, 0, 0, "R8");
        step(0, 0, 1, 'h00400, 0, "R7");
        step(0, 0, 1, 'h3FFFF, 0, "R7");
        // patterned sweep with varying contexts
        for (int i = 0; i < 200; i++) begin
            int lw, va;
            lw = (i * 7919 + 13) % 262144;
            va = (i * 104729 + 77) % 262144;
            step(i % 9 == 0, lw, i % 5 != 0, va, i % 11 == 0, "R4");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule